// File: doc/BRIEF.md
# Switching Frequency Ceiling Timer

This block is a clocked stand-in for the timing ramp that caps how often a quasi-resonant power stage may restart its switch. A fixed-point accumulator plays the part of the charged timing capacitor. The feedback error word sets how fast it rises. Once the ramp passes the ready level, the block raises a permission flag for the restart arbiter. The arbiter combines that flag with the valley detector's signal and then turns the gate on.

At full error the ramp climbs at its top rate, so the time from one gate-off to the next permission is short. That time fixes the highest frequency the stage can reach. As the error shrinks, the ramp slows and the permitted frequency folds back without limit. Above the ready level the ramp keeps rising to a ceiling and holds there. It does not free-run: only a gate-off discharge from the driver brings it back to its low level, and that discharge interval counts toward the period. A fault select hands the ramp over to the fault timer. While it is set, the ramp is frozen and permission is held on.

Ramp levels are written in units, with `UNIT` counts per unit: low level 0.5, ready level 3.0, ceiling 5.0. The error word is unsigned, and `ERR_FULL = 2**FRAC_W` represents 1.0.

Top module: `freqLimitTimer`

## Requirements
- R1: After reset, with fault select low, `rampOut` equals the low level (`UNIT/2` = 32) and `timerReady` is 0.
- R2: While charging, the accumulator gains `MAX_STEP * min(errWord, ERR_FULL)` per clock, in fractional counts of 1/`ERR_FULL` of a ramp count. Any error word above `ERR_FULL` (128) charges exactly as fast as `ERR_FULL`.
- R3: The ramp never exceeds the ceiling (`5*UNIT` = 320). Once there, it holds at that value while no gate-off arrives.
- R4: When `gateOff` is high at a clock edge and fault select is low, `rampOut` equals the low level from that edge on. The ramp then does not charge for `DISCH_CYCLES` clocks. A further `gateOff` during that interval restarts it.
- R5: With fault select low, `timerReady` is 1 exactly when no discharge interval is in progress and the ramp is at or above the ready level (`3*UNIT` = 192).
- R6: At full error, `timerReady` becomes 1 on the `DISCH_CYCLES + ceil((READY-LOW)/MAX_STEP)`-th clock edge after the gate-off edge. With the defaults that is edge 12.
- R7: An error word of 0 freezes the ramp with no wrap. If the ramp is below the ready level, `timerReady` stays 0 until the error rises again.
- R8: While `faultMode` is 1, `timerReady` is 1, and the ramp and the discharge state are frozen. `gateOff` has no effect during that time.
- R9: A smaller error stretches the period. At half of full scale, permission comes on edge `DISCH_CYCLES + 20` after gate-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| errWord | input | ERR_W | Unsigned feedback error; `ERR_FULL` means 1.0 |
| gateOff | input | 1 | Driver discharge event, sampled at the clock edge |
| faultMode | input | 1 | Hands the ramp to the fault timer |
| rampOut | output | RAMP_W | Integer part of the ramp, in counts |
| timerReady | output | 1 | Restart permission for the arbiter |

## Verification
Some properties are checked by assertions on every cycle. The ramp never passes the ceiling. A charge step never makes the ramp smaller, so there is no wrap. A gate-off always lands the ramp on the low level with permission dropped. Fault mode freezes both the ramp and the discharge state. Other behaviour only the bench scenarios can show: the exact edge counts from gate-off to permission at full and at half error, the equal rate for error words above full scale, restarting the discharge, and holding at the ceiling. The bench shows these by comparing against a cycle model of the requirements under directed and seeded random stimulus.

// File: rtl/frqLimitPkg.sv
package frqLimitPkg;

  typedef enum logic [0:0] {
    ST_CHARGE = 1'b0,
    ST_DISCH  = 1'b1
  } rampState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLow;
    logic charge;
  } rampCtl_t;

endpackage

// File: rtl/rampCtrl.sv
module rampCtrl
  import frqLimitPkg::*;
#(
  parameter int DISCH_CYCLES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     gateOff,
  input  logic     faultMode,
  output rampCtl_t ctl,
  output logic     discharging
);

  localparam int CNT_W = (DISCH_CYCLES > 1) ? $clog2(DISCH_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DISCH_CYCLES - 1);

  rampState_e      state;
  logic [CNT_W-1:0] dischCnt;

  always_comb begin
    ctl.loadLow = !faultMode && gateOff;
    ctl.charge  = !faultMode && !gateOff && (state == ST_CHARGE);
    discharging = (state == ST_DISCH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_CHARGE;
      dischCnt <= '0;
    end else if (faultMode) begin
      state    <= state;
      dischCnt <= dischCnt;
    end else if (gateOff) begin
      state    <= ST_DISCH;
      dischCnt <= CNT_LOAD;
    end else if (state == ST_DISCH) begin
      if (dischCnt == '0) begin
        state <= ST_CHARGE;
      end else begin
        dischCnt <= dischCnt - 1'b1;
      end
    end
  end

  // R8: fault select freezes the discharge sequencer
  p_fault_freeze_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultMode |=> ($stable(state) && $stable(dischCnt)));

  // R4: a discharge strobe always lands in the discharge state
  p_enter_disch_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadLow |=> (state == ST_DISCH));

endmodule

// File: rtl/rampPath.sv
module rampPath
  import frqLimitPkg::*;
#(
  parameter int RAMP_W    = 9,
  parameter int ERR_W     = 8,
  parameter int FRAC_W    = 7,
  parameter int MAX_STEP  = 16,
  parameter int LOW_LVL   = 32,
  parameter int READY_LVL = 192,
  parameter int CEIL_LVL  = 320
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ERR_W-1:0]  errWord,
  input  rampCtl_t          ctl,
  input  logic              discharging,
  input  logic              faultMode,
  output logic [RAMP_W-1:0] rampOut,
  output logic              timerReady
);

  localparam int ACC_W    = RAMP_W + FRAC_W;
  localparam int ERR_FULL = 1 << FRAC_W;
  localparam int CLAMP_W  = FRAC_W + 1;
  localparam logic [ACC_W-1:0] LOW_FX   = ACC_W'(LOW_LVL)   << FRAC_W;
  localparam logic [ACC_W-1:0] READY_FX = ACC_W'(READY_LVL) << FRAC_W;
  localparam logic [ACC_W-1:0] CEIL_FX  = ACC_W'(CEIL_LVL)  << FRAC_W;

  logic [CLAMP_W-1:0] errClamp;
  logic [ACC_W-1:0]   acc;
  logic [ACC_W-1:0]   step;
  logic [ACC_W:0]     sum;
  logic [ACC_W-1:0]   nextCharge;

  // clamp the error only when the word can exceed full scale
  generate
    if (ERR_W > FRAC_W) begin : g_clamp
      always_comb begin
        if (errWord > ERR_W'(ERR_FULL)) errClamp = CLAMP_W'(ERR_FULL);
        else                            errClamp = CLAMP_W'(errWord);
      end
    end else begin : g_noClamp
      always_comb errClamp = CLAMP_W'(errWord);
    end
  endgenerate

  always_comb begin
    step = ACC_W'(MAX_STEP) * ACC_W'(errClamp);
    sum  = {1'b0, acc} + {1'b0, step};
    if (sum > {1'b0, CEIL_FX}) nextCharge = CEIL_FX;
    else                       nextCharge = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            acc <= LOW_FX;
    else if (ctl.loadLow) acc <= LOW_FX;
    else if (ctl.charge)  acc <= nextCharge;
  end

  assign rampOut    = acc[ACC_W-1:FRAC_W];
  assign timerReady = faultMode || (!discharging && (acc >= READY_FX));

  // R3: ramp stays at or below the ceiling
  p_ceiling_r3: assert property (@(posedge clk) disable iff (!rstN)
    acc <= CEIL_FX);

  // R4: discharge returns the ramp to the low level
  p_load_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadLow |=> (rampOut == RAMP_W'(LOW_LVL)));

  // R7: a charge step never makes the ramp smaller (no wrap)
  p_no_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.charge |=> (acc >= $past(acc)));

  // R8: the ramp is frozen during fault mode
  p_fault_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    faultMode |=> $stable(acc));

endmodule

// File: rtl/freqLimitTimer.sv
module freqLimitTimer
  import frqLimitPkg::*;
#(
  parameter int RAMP_W       = 9,
  parameter int UNIT         = 64,
  parameter int ERR_W        = 8,
  parameter int FRAC_W       = 7,
  parameter int MAX_STEP     = 16,
  parameter int DISCH_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ERR_W-1:0]  errWord,
  input  logic              gateOff,
  input  logic              faultMode,
  output logic [RAMP_W-1:0] rampOut,
  output logic              timerReady
);

  localparam int LOW_LVL   = UNIT / 2;
  localparam int READY_LVL = 3 * UNIT;
  localparam int CEIL_LVL  = 5 * UNIT;

  rampCtl_t ctl;
  logic     discharging;

  rampCtrl #(
    .DISCH_CYCLES(DISCH_CYCLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .gateOff    (gateOff),
    .faultMode  (faultMode),
    .ctl        (ctl),
    .discharging(discharging)
  );

  rampPath #(
    .RAMP_W   (RAMP_W),
    .ERR_W    (ERR_W),
    .FRAC_W   (FRAC_W),
    .MAX_STEP (MAX_STEP),
    .LOW_LVL  (LOW_LVL),
    .READY_LVL(READY_LVL),
    .CEIL_LVL (CEIL_LVL)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .errWord    (errWord),
    .ctl        (ctl),
    .discharging(discharging),
    .faultMode  (faultMode),
    .rampOut    (rampOut),
    .timerReady (timerReady)
  );

  // R5: permission is withdrawn right after a gate-off
  p_ready_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    (gateOff && !faultMode) |=> (!timerReady || faultMode));

endmodule

// File: tb/freqLimitTimer_test.sv
module freqLimitTimer_test;

  localparam int RAMP_W = 9, UNIT = 64, ERR_W = 8, FRAC_W = 7;
  localparam int MAX_STEP = 16, DISCH_CYCLES = 2;
  localparam int ERR_FULL = 1 << FRAC_W;
  localparam int LOW_FX   = (UNIT / 2) << FRAC_W;
  localparam int READY_FX = (3 * UNIT) << FRAC_W;
  localparam int CEIL_FX  = (5 * UNIT) << FRAC_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ERR_W-1:0] errWord = '0;
  logic gateOff = 1'b0;
  logic faultMode = 1'b0;
  logic [RAMP_W-1:0] rampOut;
  logic timerReady;

  int checks = 0;
  int errors = 0;
  int mAcc = LOW_FX;
  int mDisch = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  freqLimitTimer #(
    .RAMP_W(RAMP_W), .UNIT(UNIT), .ERR_W(ERR_W), .FRAC_W(FRAC_W),
    .MAX_STEP(MAX_STEP), .DISCH_CYCLES(DISCH_CYCLES)
  ) uut (
    .clk(clk), .rstN(rstN), .errWord(errWord), .gateOff(gateOff),
    .faultMode(faultMode), .rampOut(rampOut), .timerReady(timerReady)
  );

  function automatic int stepOf(int e);
    int ec;
    ec = (e > ERR_FULL) ? ERR_FULL : e;
    return MAX_STEP * ec;
  endfunction

  function automatic bit readyOf(bit f);
    return f || (mDisch == 0 && mAcc >= READY_FX);
  endfunction

  function automatic int chargeEdges(int e);
    return ((READY_FX - LOW_FX) + stepOf(e) - 1) / stepOf(e);
  endfunction

  task automatic modelStep(int e, bit g, bit f);
    if (f) begin
    end else if (g) begin
      mAcc = LOW_FX;
      mDisch = DISCH_CYCLES;
    end else if (mDisch > 0) begin
      mDisch = mDisch - 1;
    end else begin
      mAcc = mAcc + stepOf(e);
      if (mAcc > CEIL_FX) mAcc = CEIL_FX;
    end
  endtask

  task automatic checkVal(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(int e, bit g, bit f, string tag);
    errWord = ERR_W'(e);
    gateOff = g;
    faultMode = f;
    @(posedge clk);
    modelStep(e, g, f);
    @(negedge clk);
    checkVal({tag, " ramp"}, int'(rampOut), mAcc >> FRAC_W);
    checkVal({tag, " ready"}, int'(timerReady), int'(readyOf(f)));
  endtask

  task automatic measure(int e, output int n);
    tick(e, 1'b1, 1'b0, "R4");
    n = 0;
    do begin
      tick(e, 1'b0, 1'b0, "R5");
      n++;
    end while (!timerReady && n < 5000);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL R6 watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkVal("R1 ramp", int'(rampOut), LOW_FX >> FRAC_W);
    checkVal("R1 ready", int'(timerReady), 0);

    // R3: climb to ceiling and hold
    for (int i = 0; i < 40; i++) tick(ERR_FULL, 1'b0, 1'b0, "R3");
    checkVal("R3 ceiling", int'(rampOut), CEIL_FX >> FRAC_W);
    tick(ERR_FULL, 1'b0, 1'b0, "R3");
    checkVal("R3 hold", int'(rampOut), CEIL_FX >> FRAC_W);

    // R6: minimum period at full error
    measure(ERR_FULL, n);
    checkVal("R6 period", n, DISCH_CYCLES + chargeEdges(ERR_FULL));
    checkVal("R6 default", n, 12);

    // R2: error above full scale charges as full scale
    measure(255, n);
    checkVal("R2 clamp period", n, DISCH_CYCLES + chargeEdges(ERR_FULL));
    measure(200, n);
    checkVal("R2 clamp period 200", n, 12);

    // R9: fold back at half and small error
    measure(ERR_FULL / 2, n);
    checkVal("R9 half period", n, DISCH_CYCLES + 20);
    measure(5, n);
    checkVal("R9 small period", n, DISCH_CYCLES + chargeEdges(5));

    // R7: zero error freezes below threshold
    tick(ERR_FULL, 1'b1, 1'b0, "R4");
    for (int i = 0; i < 4; i++) tick(ERR_FULL, 1'b0, 1'b0, "R7");
    held = int'(rampOut);
    for (int i = 0; i < 30; i++) tick(0, 1'b0, 1'b0, "R7");
    checkVal("R7 frozen", int'(rampOut), held);
    checkVal("R7 ready low", int'(timerReady), 0);
    // R7: zero error at ceiling does not wrap
    for (int i = 0; i < 40; i++) tick(ERR_FULL, 1'b0, 1'b0, "R7");
    for (int i = 0; i < 5; i++) tick(0, 1'b0, 1'b0, "R7");
    checkVal("R7 no wrap", int'(rampOut), CEIL_FX >> FRAC_W);

    // R8: fault mode holds ready, ignores gate-off
    tick(ERR_FULL, 1'b1, 1'b0, "R4");
    for (int i = 0; i < 5; i++) tick(ERR_FULL, 1'b0, 1'b0, "R8");
    held = int'(rampOut);
    for (int i = 0; i < 6; i++) tick(ERR_FULL, i[0], 1'b1, "R8");
    checkVal("R8 ramp held", int'(rampOut), held);
    checkVal("R8 ready forced", int'(timerReady), 1);
    tick(ERR_FULL, 1'b0, 1'b0, "R8");
    checkVal("R8 resume", int'(rampOut), held + (stepOf(ERR_FULL) >> FRAC_W));

    // R4: retrigger during discharge
    tick(ERR_FULL, 1'b1, 1'b0, "R4");
    tick(ERR_FULL, 1'b1, 1'b0, "R4");
    tick(ERR_FULL, 1'b0, 1'b0, "R4");
    checkVal("R4 still low", int'(rampOut), LOW_FX >> FRAC_W);
    tick(ERR_FULL, 1'b0, 1'b0, "R4");
    tick(ERR_FULL, 1'b0, 1'b0, "R4");
    checkVal("R4 charging", int'(rampOut), (LOW_FX + stepOf(ERR_FULL)) >> FRAC_W);

    // R5: seeded random mix against the model
    for (int i = 0; i < 4000; i++) begin
      int e;
      int r;
      r = int'($urandom_range(9, 0));
      if (r < 2)      e = 0;
      else if (r < 4) e = int'($urandom_range(255, 129));
      else            e = int'($urandom_range(ERR_FULL, 1));
      tick(e, ($urandom_range(11, 0) == 0), ($urandom_range(39, 0) == 0), "R5");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule